// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block keeps a small bank of hardware tokens that two ports (left and right) use to coordinate access to shared resources from software. Each token is a latch with an owner. A port asks for a token by writing 0 to it and gives it back by writing 1. When a port reads a token it sees 0 if it holds the token and 1 if it does not. If the other port asks for a token while it is held, the request is remembered. That port then takes the token on the same clock edge on which the owner releases it.

The token space is separate from the main memory. A port reaches it only when its token select is high and its memory enable is low. A port that raises both signals does not touch the tokens. A read copies the token value into a per-port output register. The register drives the value on every data bit and keeps it until that port makes its next read, so a write from the other port cannot disturb it. Writes take effect on the clock edge that samples them.

Each token is a five-state machine:
- FREE: no owner.
- OWN_L: the left port holds the token.
- OWN_R: the right port holds the token.
- L_PEND_R: the left port holds the token and the right port is waiting.
- R_PEND_L: the right port holds the token and the left port is waiting.

Transitions, where "L0" means the left port writes 0 (and likewise for L1, R0, R1):
- FREE: L0 together with R0 goes to L_PEND_R (tie-break). L0 alone goes to OWN_L. R0 alone goes to OWN_R.
- OWN_L: L1 goes to OWN_R if R0 arrives in the same cycle, otherwise to FREE. R0 without L1 goes to L_PEND_R.
- L_PEND_R: L1 goes to OWN_R (handover), or to FREE if R1 arrives in the same cycle. R1 alone goes to OWN_L (cancel).
- OWN_R and R_PEND_L mirror OWN_L and L_PEND_R with the ports swapped.
- Any other input combination leaves the state unchanged.

Top module: `sem_token_bank`

## Requirements
- R1: There are NUM_TOK (default 8) independent tokens. A token is selected by the low log2(NUM_TOK) address bits, and all higher address bits are ignored.
- R2: A port accesses the tokens only in a cycle with sel=1 and memen=0. With memen=1, writes change no token and reads leave the read register as it was.
- R3: A write takes its value from the write bit: 0 is a request and 1 is a release, or a cancel of a pending request.
- R4: After one port requests a free token, that port reads 0 at that token and the other port reads 1.
- R5: While a token is held, only the owner's release changes which port holds it. A request from the non-owner leaves the owner unchanged.
- R6: If the non-owner has a pending request when the owner writes 1, the non-owner becomes owner on that edge. Otherwise the token becomes free.
- R7: A read returns the token value on all DATA_W bits of rdata: all 0s when the port holds the token, all 1s when it does not.
- R8: A read samples the token state as it was before the edge on which the read is taken. The result appears one cycle later and is held unchanged until that port's next read, whatever the other port does.
- R9: When both ports request a free token in the same cycle, the left port becomes owner and the right request stays pending.
- R10: After reset every token is FREE, and both read registers hold all 1s.
- R11: A non-owner writing 1 while its request is pending cancels the request. The owner keeps the token, and its later release frees the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_sel | input | 1 | Left token select |
| lft_memen | input | 1 | Left memory enable; blocks token access when 1 |
| lft_we | input | 1 | Left write (1) or read (0) |
| lft_addr | input | ADDR_W | Left address; low bits pick the token |
| lft_wbit | input | 1 | Left write value (0 request, 1 release) |
| lft_rdata | output | DATA_W | Left read register |
| rgt_sel | input | 1 | Right token select |
| rgt_memen | input | 1 | Right memory enable; blocks token access when 1 |
| rgt_we | input | 1 | Right write (1) or read (0) |
| rgt_addr | input | ADDR_W | Right address; low bits pick the token |
| rgt_wbit | input | 1 | Right write value (0 request, 1 release) |
| rgt_rdata | output | DATA_W | Right read register |

## Verification
A wrong state in any token shows up on the next read of that token by either port, one cycle after the read is issued. Wrong states include a lost pending request, a token held by both sides, or a missed handover. The bench reads both ports after every write, so a fault shows up within two cycles of the write that caused it. A long pseudo-random sequence covers every input pair in every state of every token, with random upper address bits. Directed runs cover the tie-break, cancel, blocked access and hold cases.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [2:0] {
        ST_FREE     = 3'd0,
        ST_OWN_L    = 3'd1,
        ST_OWN_R    = 3'd2,
        ST_L_PEND_R = 3'd3,
        ST_R_PEND_L = 3'd4
    } tok_state_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              sel,
    input  logic              memen,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              do_wr,
    output logic              do_rd,
    output logic [IDX_W-1:0]  idx
);
    logic acc;

    always_comb begin
        // only the token space, never together with memory access
        acc   = sel && !memen;
        do_wr = acc && we;
        do_rd = acc && !we;
        idx   = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/sem_token_fsm.sv
module sem_token_fsm
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_we,
    input  logic l_bit,
    input  logic r_we,
    input  logic r_bit,
    output logic l_holds,
    output logic r_holds
);
    tok_state_t st, nxt;
    logic lq, lr, rq, rr;

    always_comb begin
        lq = l_we && !l_bit;
        lr = l_we && l_bit;
        rq = r_we && !r_bit;
        rr = r_we && r_bit;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_FREE: begin
                if (lq && rq)  nxt = ST_L_PEND_R;
                else if (lq)   nxt = ST_OWN_L;
                else if (rq)   nxt = ST_OWN_R;
            end
            ST_OWN_L: begin
                if (lr)        nxt = rq ? ST_OWN_R : ST_FREE;
                else if (rq)   nxt = ST_L_PEND_R;
            end
            ST_L_PEND_R: begin
                if (lr)        nxt = rr ? ST_FREE : ST_OWN_R;
                else if (rr)   nxt = ST_OWN_L;
            end
            ST_OWN_R: begin
                if (rr)        nxt = lq ? ST_OWN_L : ST_FREE;
                else if (lq)   nxt = ST_R_PEND_L;
            end
            ST_R_PEND_L: begin
                if (rr)        nxt = lr ? ST_FREE : ST_OWN_L;
                else if (lr)   nxt = ST_OWN_R;
            end
            default:           nxt = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_FREE;
        else        st <= nxt;
    end

    always_comb begin
        l_holds = (st == ST_OWN_L) || (st == ST_L_PEND_R);
        r_holds = (st == ST_OWN_R) || (st == ST_R_PEND_L);
    end

    // R5
    owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_holds && !lr) |=> l_holds);
    // R6
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L_PEND_R && lr && !rr) |=> (r_holds && !l_holds));
    // R9
    tie_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREE && lq && rq) |=> (st == ST_L_PEND_R));
    // R11
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_R_PEND_L && lr && !rr) |=> (st == ST_OWN_R));
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              view,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '1;
        else if (rd_en) rdata <= {DATA_W{view}};
    end

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
    parameter int NUM_TOK = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_sel,
    input  logic              lft_memen,
    input  logic              lft_we,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_wbit,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              rgt_sel,
    input  logic              rgt_memen,
    input  logic              rgt_we,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_wbit,
    output logic [DATA_W-1:0] rgt_rdata
);
    localparam int IDX_W = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1;

    logic             l_wr, l_rd, r_wr, r_rd;
    logic [IDX_W-1:0] l_idx, r_idx;
    logic [NUM_TOK-1:0] l_hold_v, r_hold_v;
    logic l_view, r_view;

    sem_port_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_l (
        .sel(lft_sel), .memen(lft_memen), .we(lft_we), .addr(lft_addr),
        .do_wr(l_wr), .do_rd(l_rd), .idx(l_idx));

    sem_port_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_r (
        .sel(rgt_sel), .memen(rgt_memen), .we(rgt_we), .addr(rgt_addr),
        .do_wr(r_wr), .do_rd(r_rd), .idx(r_idx));

    for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
        logic l_hit, r_hit;
        always_comb begin
            l_hit = l_wr && (l_idx == IDX_W'(t));
            r_hit = r_wr && (r_idx == IDX_W'(t));
        end
        sem_token_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .l_we(l_hit), .l_bit(lft_wbit),
            .r_we(r_hit), .r_bit(rgt_wbit),
            .l_holds(l_hold_v[t]), .r_holds(r_hold_v[t]));
    end

    always_comb begin
        l_view = !l_hold_v[l_idx];
        r_view = !r_hold_v[r_idx];
    end

    sem_rd_reg #(.DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .view(l_view), .rdata(lft_rdata));

    sem_rd_reg #(.DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .view(r_view), .rdata(rgt_rdata));

    // R2
    blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!lft_sel || lft_memen) && (!rgt_sel || rgt_memen))
        |=> ($stable(l_hold_v) && $stable(r_hold_v)
             && $stable(lft_rdata) && $stable(rgt_rdata)));
    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_hold_v & r_hold_v) == '0);
endmodule

// File: tb/sem_token_bank_test.sv
`timescale 1ns/1ps
module sem_token_bank_test;
    localparam int NT = 8;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic ls, lm, lw, ld, rs, rm, rw, rd;
    logic [AW-1:0] la, ra;
    logic [DW-1:0] lq, rq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int owner [NT];
    bit pl [NT];
    bit pr [NT];

    always #2.5 clk = ~clk;

    sem_token_bank #(.NUM_TOK(NT), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lft_sel(ls), .lft_memen(lm), .lft_we(lw), .lft_addr(la), .lft_wbit(ld), .lft_rdata(lq),
        .rgt_sel(rs), .rgt_memen(rm), .rgt_we(rw), .rgt_addr(ra), .rgt_wbit(rd), .rgt_rdata(rq));

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ls = 0; lm = 0; lw = 0; ld = 0; la = '0;
        rs = 0; rm = 0; rw = 0; rd = 0; ra = '0;
    endtask

    // one cycle of port activity; op: 0 none, 1 write 0, 2 write 1, 3 read
    task automatic cyc(input int lop, input logic [AW-1:0] lad, input int rop, input logic [AW-1:0] rad);
        @(negedge clk);
        ls = (lop != 0); lm = 0; lw = (lop == 1 || lop == 2); ld = (lop == 2); la = lad;
        rs = (rop != 0); rm = 0; rw = (rop == 1 || rop == 2); rd = (rop == 2); ra = rad;
    endtask

    // model of one token, from the requirements
    task automatic model(input int t, input int lop, input int rop);
        bit lreq, lrel, rreq, rrel;
        lreq = (lop == 1); lrel = (lop == 2);
        rreq = (rop == 1); rrel = (rop == 2);
        if (owner[t] == 0) begin
            if (lreq) begin owner[t] = 1; pr[t] = rreq; end
            else if (rreq) owner[t] = 2;
        end else if (owner[t] == 1) begin
            if (lrel) begin
                owner[t] = ((pr[t] && !rrel) || rreq) ? 2 : 0;
                pr[t] = 0;
            end else begin
                if (rreq) pr[t] = 1;
                if (rrel) pr[t] = 0;
            end
        end else begin
            if (rrel) begin
                owner[t] = ((pl[t] && !lrel) || lreq) ? 1 : 0;
                pl[t] = 0;
            end else begin
                if (lreq) pl[t] = 1;
                if (lrel) pl[t] = 0;
            end
        end
    endtask

    function automatic logic [DW-1:0] expv(input int t, input int side);
        return (owner[t] == side) ? '0 : '1;
    endfunction

    task automatic read_both(input int t, input string tag);
        logic [AW-1:0] hi;
        hi = AW'($urandom) & ~AW'(NT - 1);
        cyc(3, hi | AW'(t), 3, AW'(t));
        idle();
        chk({tag, " left"}, lq, expv(t, 1));
        chk({tag, " right"}, rq, expv(t, 2));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int t = 0; t < NT; t++) begin owner[t] = 0; pl[t] = 0; pr[t] = 0; end
        ls = 0; lm = 0; lw = 0; ld = 0; la = '0;
        rs = 0; rm = 0; rw = 0; rd = 0; ra = '0;
        repeat (3) @(negedge clk);
        // R10 reset registers
        chk("R10 left reset", lq, '1);
        chk("R10 right reset", rq, '1);
        rst_n = 1;
        for (int t = 0; t < NT; t++) read_both(t, "R10 free");

        // R4 R3 left request on token 2
        cyc(1, 16'h0002, 0, '0); model(2, 1, 0);
        read_both(2, "R4 R3");
        // R1 other tokens untouched, upper bits ignored
        cyc(3, 16'hA005, 3, 16'h7F02); idle();
        chk("R1 left tok5", lq, '1);
        chk("R1 right tok2 high bits", rq, '1);
        // R5 right request on held token: still left
        cyc(0, '0, 1, 16'h0002); model(2, 0, 1);
        read_both(2, "R5 held");
        // R6 handover
        cyc(2, 16'h0002, 0, '0); model(2, 2, 0);
        read_both(2, "R6 handover");
        chk("R6 right owns", rq, '0);
        // R11 cancel: left asks, left cancels, right releases -> free
        cyc(1, 16'h0002, 0, '0); model(2, 1, 0);
        cyc(2, 16'h0002, 0, '0); model(2, 2, 0);
        cyc(0, '0, 2, 16'h0002); model(2, 0, 2);
        read_both(2, "R11 cancel");
        chk("R11 free left", lq, '1);
        // R9 tie-break on token 6
        cyc(1, 16'h0006, 1, 16'h0006); model(6, 1, 1);
        read_both(6, "R9 tie");
        chk("R9 left wins", lq, '0);
        cyc(2, 16'h0006, 0, '0); model(6, 2, 0);
        read_both(6, "R9 pending");
        chk("R9 right got it", rq, '0);
        // R2 blocked write with memory enable on token 0
        @(negedge clk);
        ls = 1; lm = 1; lw = 1; ld = 0; la = 16'h0000;
        rs = 1; rm = 1; rw = 0; ra = 16'h0006;
        idle();
        chk("R2 blocked read keeps right", rq, '0);
        read_both(0, "R2 blocked write");
        // R8 hold: right reads token 6 (owns), then left grabs? right releases via left
        cyc(0, '0, 3, 16'h0006); idle();
        chk("R8 captured", rq, '0);
        cyc(0, '0, 2, 16'h0006); model(6, 0, 2);
        cyc(1, 16'h0006, 0, '0); model(6, 1, 0);
        idle();
        chk("R8 right held", rq, '0);
        // R8 read sees state before edge: right reads while left releases
        cyc(2, 16'h0006, 3, 16'h0006); model(6, 2, 0);
        idle();
        chk("R8 pre-edge", rq, '1);
        // R7 covered by full-width compares; sweep
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            int t, lop, rop;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            t = int'(lf[2:0]);
            lop = int'(lf[5:4]) % 3;
            rop = int'(lf[9:8]) % 3;
            cyc(lop, {lf[15:3], 3'(t)}, rop, {lf[12:0], 3'(t)});
            model(t, lop, rop);
            read_both(t, "R7 R3 sweep");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule